// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter with Break

This block sends characters on an asynchronous serial line. A one-character holding register sits in front of a shift register, so software can load the next character while the current one is still on the wire. A write strobe with a character loads the holding register. The holding register hands the character to the shifter as soon as the shifter is idle, which is the cycle after the write. The ready flag therefore drops for a single cycle after the first load and then rises again. After a second load, the flag stays low until the running frame has ended.

The frame format is sampled when a character enters the shifter. It has 5 to 8 data bits, optional odd or even parity, and one, one and a half or two stop bits. Bit timing comes from a 16x oversampling tick that is supplied from outside. A break control forces the line to space (low) without stopping the shifter, so the ready flag keeps cycling and software can time a break by sending dummy characters. A maintenance copy of the line is provided for a receiver loopback path.

The shifter state machine has five states. IDLE goes to START when the holding register is full. START goes to DATA after one bit time. DATA goes to PARITY or STOP after the last data bit. PARITY goes to STOP after one bit time. STOP goes to IDLE when the stop time has elapsed. From IDLE, a waiting character starts the next frame with no idle gap on the line.

Top module: `uart_xmit_dbuf`

## Requirements
- R1: After reset, ser_out and loop_out are high (mark) and rdy is high.
- R2: A write accepted while rdy is high makes rdy low in the next cycle. When the shifter is idle, rdy is high again one cycle later because the character has moved into the shifter.
- R3: A write made while a frame is being sent keeps rdy low until that frame's stop time ends. Measured in ticks from the load of the running frame, rdy rises at the frame length.
- R4: A write made while rdy is low is ignored. No extra frame appears on the line, and the held character is unchanged.
- R5: A frame begins with a low start bit, followed by the data bits LSB first. The number of data bits is 5 + fmt_len (fmt_len 0 gives 5 bits, 3 gives 8). Only the low bits of the character are sent.
- R6: When fmt_par_en is 1, a parity bit follows the data. With fmt_par_odd = 1, the data bits plus the parity bit hold an odd number of ones; with fmt_par_odd = 0, they hold an even number.
- R7: The stop period is high. fmt_stop 0 gives 16 ticks, 1 gives 24 ticks, and 2 or 3 give 32 ticks.
- R8: The start bit, each data bit and the parity bit last 16 ticks each. A character already waiting in the holding register starts its start bit directly after the stop period, with no idle time.
- R9: While brk_en is 1, ser_out stays low continuously, and rdy rises and falls exactly as it does during normal transmission.
- R10: loop_out always equals ser_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_char | input | DW | Character, right-justified |
| fmt_len | input | 2 | Data length code; the length is 5 + code |
| fmt_stop | input | 2 | Stop code: 0 is 1 bit, 1 is 1.5 bits, 2 or 3 is 2 bits |
| fmt_par_en | input | 1 | Parity bit enable |
| fmt_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| brk_en | input | 1 | Forces a continuous space on the line |
| ser_out | output | 1 | Serial line, mark when idle |
| rdy | output | 1 | Holding register empty |
| loop_out | output | 1 | Maintenance copy of the line for receiver loopback |

## Verification
The embedded assertions check the following on every cycle:
- An accepted write fills the holding register.
- A write made while the holding register is full leaves the held character unchanged.
- The stop state always drives mark.
- The tick counter never runs past one bit time outside the stop state.
- The data index stays below the latched length.

Other behaviours can only be shown by the bench's scenarios, because they depend on the line as a whole and on counts of ticks:
- the bit order and parity value of real frames;
- the 24-tick and 32-tick stop periods, shown through the spacing between back-to-back frames;
- the one-cycle dip of rdy after a write;
- the absence of a frame for an ignored write;
- the rdy timing while brk_en holds the line low.

// File: rtl/uxd_pkg.sv
package uxd_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP
    } tx_state_e;

    // stop period in oversampling ticks for a stop code
    function automatic int unsigned stop_ticks(input logic [1:0] code, input int unsigned osr);
        unique case (code)
            2'b00:   return osr;
            2'b01:   return osr + osr / 2;
            default: return 2 * osr;
        endcase
    endfunction

endpackage

// File: rtl/uxd_hold.sv
module uxd_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [DW-1:0] wr_char,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] held
);

    logic accept;
    assign accept = wr_stb && !full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            held <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (accept) begin
            full <= 1'b1;
            held <= wr_char;
        end
    end

    // R2
    hold_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> full);

    // R4
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && full) |=> $stable(held));

endmodule

// File: rtl/uxd_shift.sv
module uxd_shift
    import uxd_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          avail,
    input  logic [DW-1:0] char_in,
    input  logic [1:0]    len_code,
    input  logic [1:0]    stop_code,
    input  logic          par_en,
    input  logic          par_odd,
    output logic          take,
    output logic          line
);

    localparam int TW = $clog2(2 * OSR + 1);
    localparam int BW = $clog2(DW + 1);

    tx_state_e st, st_nx;

    logic [TW-1:0] tcnt;
    logic [TW-1:0] slim;
    logic [TW-1:0] lim;
    logic [BW-1:0] bidx;
    logic [BW-1:0] nlat;
    logic [DW-1:0] sh;
    logic          pbit;
    logic          pen;
    logic          bit_end;
    logic          last_data;

    logic [BW-1:0] n_req;
    logic [DW-1:0] mask;
    logic [DW-1:0] masked;
    logic [TW-1:0] slim_req;

    // format decode for the character about to be loaded
    always_comb begin
        n_req = BW'(DW - 3) + BW'(len_code);
        for (int i = 0; i < DW; i++) begin
            mask[i] = (i < int'(n_req));
        end
        masked   = char_in & mask;
        slim_req = TW'(stop_ticks(stop_code, OSR));
    end

    assign take      = (st == TX_IDLE) && avail;
    assign lim       = (st == TX_STOP) ? slim : TW'(OSR);
    assign bit_end   = tick && (tcnt == lim - 1'b1);
    assign last_data = (bidx == nlat - 1'b1);

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            TX_IDLE:   if (avail)   st_nx = TX_START;
            TX_START:  if (bit_end) st_nx = TX_DATA;
            TX_DATA:   if (bit_end && last_data) st_nx = pen ? TX_PARITY : TX_STOP;
            TX_PARITY: if (bit_end) st_nx = TX_STOP;
            TX_STOP:   if (bit_end) st_nx = TX_IDLE;
            default:   st_nx = TX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= st_nx;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt <= '0;
            bidx <= '0;
            nlat <= BW'(DW);
            sh   <= '0;
            pbit <= 1'b0;
            pen  <= 1'b0;
            slim <= TW'(OSR);
        end else begin
            if (st == TX_IDLE || bit_end) tcnt <= '0;
            else if (tick)                tcnt <= tcnt + 1'b1;

            if (take) begin
                sh   <= masked;
                nlat <= n_req;
                pen  <= par_en;
                pbit <= par_odd ? ~^masked : ^masked;
                slim <= slim_req;
                bidx <= '0;
            end else if (st == TX_DATA && bit_end) begin
                sh   <= sh >> 1;
                bidx <= bidx + 1'b1;
            end
        end
    end

    // line output
    always_comb begin
        unique case (st)
            TX_IDLE:   line = 1'b1;
            TX_START:  line = 1'b0;
            TX_DATA:   line = sh[0];
            TX_PARITY: line = pbit;
            TX_STOP:   line = 1'b1;
            default:   line = 1'b1;
        endcase
    end

    // R7
    stop_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_STOP) |-> line);

    // R8
    bit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != TX_STOP) |-> (tcnt < TW'(OSR)));

    // R5
    data_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_DATA) |-> (bidx < nlat));

endmodule

// File: rtl/uxd_line.sv
module uxd_line (
    input  logic brk,
    input  logic bit_in,
    output logic ser_out,
    output logic loop_out
);

    logic wire_lvl;

    assign wire_lvl = bit_in && !brk;
    assign ser_out  = wire_lvl;
    assign loop_out = wire_lvl;

endmodule

// File: rtl/uart_xmit_dbuf.sv
module uart_xmit_dbuf #(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic          wr_stb,
    input  logic [DW-1:0] wr_char,
    input  logic [1:0]    fmt_len,
    input  logic [1:0]    fmt_stop,
    input  logic          fmt_par_en,
    input  logic          fmt_par_odd,
    input  logic          brk_en,
    output logic          ser_out,
    output logic          rdy,
    output logic          loop_out
);

    logic          full;
    logic          take;
    logic [DW-1:0] held;
    logic          line_bit;

    uxd_hold #(.DW(DW)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_char (wr_char),
        .take    (take),
        .full    (full),
        .held    (held)
    );

    uxd_shift #(.DW(DW), .OSR(OSR)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .avail     (full),
        .char_in   (held),
        .len_code  (fmt_len),
        .stop_code (fmt_stop),
        .par_en    (fmt_par_en),
        .par_odd   (fmt_par_odd),
        .take      (take),
        .line      (line_bit)
    );

    uxd_line u_line (
        .brk      (brk_en),
        .bit_in   (line_bit),
        .ser_out  (ser_out),
        .loop_out (loop_out)
    );

    assign rdy = !full;

    // R2
    ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> rdy);

endmodule

// File: tb/uart_xmit_dbuf_test.sv
module uart_xmit_dbuf_test;

    typedef struct {
        logic [7:0] d;
        int         n;
        bit         pe;
        bit         pv;
        int         stop;
        bit         b2b;
    } exp_t;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       tick16 = 0;
    logic       wr_stb = 0;
    logic [7:0] wr_char = 0;
    logic [1:0] fmt_len = 2'd3;
    logic [1:0] fmt_stop = 2'd0;
    logic       fmt_par_en = 0;
    logic       fmt_par_odd = 0;
    logic       brk_en = 0;
    logic       ser_out, rdy, loop_out;

    int total = 0;
    int bad = 0;
    int tick_no = 0;
    int ccnt = 0;
    int pushed = 0;
    int seen = 0;
    int loop_mis = 0;
    bit mon_en = 1;
    exp_t exp_q[$];

    uart_xmit_dbuf uut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_stb(wr_stb), .wr_char(wr_char),
        .fmt_len(fmt_len), .fmt_stop(fmt_stop), .fmt_par_en(fmt_par_en),
        .fmt_par_odd(fmt_par_odd), .brk_en(brk_en), .ser_out(ser_out), .rdy(rdy),
        .loop_out(loop_out)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        ccnt   <= (ccnt == 3) ? 0 : ccnt + 1;
        tick16 <= (ccnt == 2);
        if (tick16) tick_no <= tick_no + 1;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic wait_tick_at(input int t);
        while (tick_no < t) @(negedge clk);
    endtask

    // driver: aligned write, pushes the expected frame
    task automatic send(input logic [7:0] d, input bit b2b);
        exp_t e;
        int ones;
        @(negedge clk);
        while (!tick16) @(negedge clk);
        @(negedge clk);
        wr_stb = 1; wr_char = d;
        @(negedge clk);
        wr_stb = 0;
        e.n = 5 + int'(fmt_len);
        ones = 0;
        for (int i = 0; i < 8; i++) if (i < e.n && d[i]) ones++;
        e.d = d; e.pe = fmt_par_en;
        e.pv = fmt_par_odd ? ((ones % 2) == 0) : ((ones % 2) == 1);
        e.stop = (fmt_stop == 2'd0) ? 16 : (fmt_stop == 2'd1) ? 24 : 32;
        e.b2b = b2b;
        if (mon_en) begin
            exp_q.push_back(e);
            pushed++;
        end
    endtask

    // monitor
    initial begin
        int prev_end;
        bit have_prev;
        have_prev = 0;
        prev_end = 0;
        forever begin
            @(negedge clk);
            if (rst_n && mon_en && ser_out === 1'b0) begin
                int t0;
                int p;
                exp_t e;
                t0 = tick_no;
                if (exp_q.size() == 0) begin
                    chk(0, "R4", "unexpected frame", 1, 0);
                    wait_tick_at(t0 + 400);
                end else begin
                    e = exp_q.pop_front();
                    seen++;
                    if (have_prev && e.b2b)
                        chk(t0 == prev_end, "R8", "back-to-back start tick", t0, prev_end);
                    wait_tick_at(t0 + 8);
                    chk(ser_out == 1'b0, "R5", "start bit", ser_out, 0);
                    for (int i = 0; i < e.n; i++) begin
                        wait_tick_at(t0 + 8 + 16 * (i + 1));
                        chk(ser_out == e.d[i], "R5", $sformatf("data bit %0d", i), ser_out, e.d[i]);
                    end
                    p = e.pe ? 1 : 0;
                    if (e.pe) begin
                        wait_tick_at(t0 + 8 + 16 * (e.n + 1));
                        chk(ser_out == e.pv, "R6", "parity bit", ser_out, e.pv);
                    end
                    wait_tick_at(t0 + 8 + 16 * (e.n + 1 + p));
                    chk(ser_out == 1'b1, "R7", "stop level", ser_out, 1);
                    prev_end = t0 + 16 * (1 + e.n + p) + e.stop;
                    have_prev = 1;
                end
            end
        end
    end

    always @(negedge clk) if (ser_out !== loop_out) loop_mis++;

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int t0;
        int highs;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(ser_out == 1'b1, "R1", "ser_out in reset", ser_out, 1);
        chk(rdy == 1'b1, "R1", "rdy in reset", rdy, 1);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk(loop_out == 1'b1, "R1", "loop_out after reset", loop_out, 1);

        // 8N1 back-to-back, R2 R3 R4
        fmt_len = 2'd3; fmt_stop = 2'd0; fmt_par_en = 0;
        send(8'hA5, 0);
        t0 = tick_no;
        chk(rdy == 1'b0, "R2", "rdy after first write", rdy, 0);
        @(negedge clk);
        chk(rdy == 1'b1, "R2", "rdy after move to shifter", rdy, 1);
        send(8'h5A, 1);
        chk(rdy == 1'b0, "R3", "rdy after second write", rdy, 0);
        wr_stb = 1; wr_char = 8'hFF;
        @(negedge clk);
        wr_stb = 0;
        @(negedge clk);
        chk(rdy == 1'b0, "R4", "rdy after ignored write", rdy, 0);
        while (!rdy) @(negedge clk);
        chk(tick_no == t0 + 160, "R3", "tick of rdy rise", tick_no, t0 + 160);
        wait_tick_at(tick_no + 200);

        // 7 bits, odd parity, 2 stop
        fmt_len = 2'd2; fmt_stop = 2'd2; fmt_par_en = 1; fmt_par_odd = 1;
        send(8'h3C, 0);
        @(negedge clk);
        send(8'hC1, 1);
        wait_tick_at(tick_no + 400);

        // 5 bits, even parity, 1.5 stop
        fmt_len = 2'd0; fmt_stop = 2'd1; fmt_par_en = 1; fmt_par_odd = 0;
        send(8'hFF, 0);
        @(negedge clk);
        send(8'h13, 1);
        wait_tick_at(tick_no + 300);

        // break R9
        mon_en = 0;
        brk_en = 1;
        fmt_len = 2'd3; fmt_stop = 2'd0; fmt_par_en = 0;
        send(8'hFF, 0);
        t0 = tick_no;
        chk(rdy == 1'b0, "R9", "rdy after write in break", rdy, 0);
        @(negedge clk);
        chk(rdy == 1'b1, "R9", "rdy re-set in break", rdy, 1);
        send(8'hFF, 0);
        highs = 0;
        while (!rdy) begin
            @(negedge clk);
            if (ser_out) highs++;
        end
        chk(tick_no == t0 + 160, "R9", "tick of rdy rise in break", tick_no, t0 + 160);
        while (tick_no < t0 + 330) begin
            @(negedge clk);
            if (ser_out) highs++;
        end
        chk(highs == 0, "R9", "mark samples during break", highs, 0);
        brk_en = 0;
        @(negedge clk);
        chk(ser_out == 1'b1, "R9", "line after break", ser_out, 1);
        mon_en = 1;

        wait_tick_at(tick_no + 100);
        chk(ser_out == 1'b1, "R4", "idle line at end", ser_out, 1);
        chk(seen == pushed, "R4", "frames seen", seen, pushed);
        chk(exp_q.size() == 0, "R5", "frames left", exp_q.size(), 0);
        chk(loop_mis == 0, "R10", "loop_out mismatches", loop_mis, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule